// File: doc/BRIEF.md
# Multi-Stream Direction-Detecting Prefetcher

This block watches the stream of first-level cache miss addresses and turns them into sequential prefetch requests. Addresses are cache-block addresses, so one unit is one block. A miss that lands near no tracked stream opens a new stream entry. That entry then learns from later nearby misses whether the stream is ascending or descending. Once the direction is known, the stream issues requests for the next blocks in that direction, up to a fixed distance ahead of the latest demand miss.

A fixed number of stream entries is kept. Free entries are used first. After that, a new stream replaces the entry that was touched least recently. Requests leave through a valid/ready handshake, one per cycle. Looking up the cache, accessing memory and dropping prefetches that the cache already holds are left to the surrounding logic.

Top module: `dirstream_prefetch`

## Requirements
- R1: After reset no stream is tracked and `pf_valid` is low.
- R2: A miss that is within no stream's window opens a new stream. A stream issues no request while it has seen only its opening miss and, at most, one further miss that changed the address.
- R3: The second further miss with a non-zero delta fixes the direction. The direction is descending when that miss's address is lower than the previous one, and ascending otherwise, whatever the earlier delta was.
- R4: A miss belongs to a stream when its address differs from the stream's last address by at most WINDOW blocks (16) in either direction, with both ends included. At 17 blocks it opens a new stream instead. When several streams match, the lowest-numbered entry takes the miss.
- R5: A trained stream requests consecutive blocks, starting one block past its last miss in its direction, and stops after the block DIST (4) blocks past that miss.
- R6: While `pf_valid` is high and `pf_ready` is low, with no new miss, the request stays valid and `pf_addr` stays unchanged. No request is lost or repeated.
- R7: A new miss in a trained stream moves its last address. Requests resume from the first block past the miss if the earlier requests had fallen behind it, and otherwise continue from where they stopped.
- R8: There are 16 entries. When all of them are in use, an unmatched miss replaces the entry that matched or opened a miss least recently.
- R9: A miss equal to a stream's last address only refreshes that stream's recency. It does not advance training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer accepts the request this cycle |
| pf_addr | output | ADDR_W | Block address to prefetch |

## Verification
The hardest case to reach from the ports is replacement. It needs every entry filled and a known recency order, and a stream's disappearance can only be seen through what it then fails to issue. The bench opens sixteen streams far apart and refreshes the first one with a zero-delta miss. It then forces one eviction and follows up with two misses beside the evicted stream: if that stream had survived, those misses would train it. Two more misses beside the refreshed stream must train it, which shows it outlived both evictions.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
   typedef enum logic [1:0] {
      ST_FREE   = 2'd0,
      ST_SEEDED = 2'd1,
      ST_LEAN   = 2'd2,
      ST_LOCKED = 2'd3
   } strm_state_e;
endpackage

// File: rtl/dsp_match.sv
`timescale 1ns/1ps
module dsp_match #(
   parameter int ADDR_W = 32,
   parameter int NUM_STREAMS = 16,
   parameter int WINDOW = 16,
   localparam int IDX_W = $clog2(NUM_STREAMS)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [ADDR_W-1:0]                      probe_addr,
   input  logic [NUM_STREAMS-1:0]                 live_vec,
   input  logic [NUM_STREAMS-1:0][ADDR_W-1:0]     last_vec,
   output logic                                   hit,
   output logic [IDX_W-1:0]                       hit_idx
);
   localparam logic signed [ADDR_W-1:0] WIN_HI = ADDR_W'(WINDOW);
   localparam logic signed [ADDR_W-1:0] WIN_LO = -WIN_HI;

   logic [NUM_STREAMS-1:0] near_vec;

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_cmp
      logic signed [ADDR_W-1:0] gap;
      assign gap = $signed(probe_addr - last_vec[g]);
      assign near_vec[g] = live_vec[g] && (gap <= WIN_HI) && (gap >= WIN_LO);
   end

   always_comb begin
      hit = 1'b0;
      hit_idx = '0;
      for (int k = NUM_STREAMS - 1; k >= 0; k--) begin
         if (near_vec[k]) begin
            hit = 1'b1;
            hit_idx = IDX_W'(k);
         end
      end
   end

   // R4
   hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> live_vec[hit_idx]);
endmodule

// File: rtl/dsp_lru.sv
`timescale 1ns/1ps
module dsp_lru #(
   parameter int NUM_STREAMS = 16,
   localparam int IDX_W = $clog2(NUM_STREAMS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] oldest_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_STREAMS - 1);

   logic [NUM_STREAMS-1:0][IDX_W-1:0] rank_q;
   logic [NUM_STREAMS-1:0]            oldest_vec;

   always_ff @(posedge clk) begin
      for (int j = 0; j < NUM_STREAMS; j++) begin
         if (!rst_n) begin
            rank_q[j] <= IDX_W'(j);
         end else if (touch) begin
            if (touch_idx == IDX_W'(j)) begin
               rank_q[j] <= '0;
            end else if (rank_q[j] < rank_q[touch_idx]) begin
               rank_q[j] <= rank_q[j] + 1'b1;
            end
         end
      end
   end

   always_comb begin
      oldest_idx = '0;
      for (int j = 0; j < NUM_STREAMS; j++) begin
         oldest_vec[j] = (rank_q[j] == OLDEST);
         if (oldest_vec[j]) oldest_idx = IDX_W'(j);
      end
   end

   // R8
   touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> rank_q[$past(touch_idx)] == '0);
   // R8
   single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);
endmodule

// File: rtl/dsp_issue.sv
`timescale 1ns/1ps
module dsp_issue #(
   parameter int NUM_STREAMS = 16,
   localparam int IDX_W = $clog2(NUM_STREAMS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STREAMS-1:0] pend_vec,
   output logic [NUM_STREAMS-1:0] grant_vec,
   output logic                   any,
   output logic [IDX_W-1:0]       grant_idx
);
   always_comb begin
      grant_vec = '0;
      grant_idx = '0;
      any = 1'b0;
      for (int k = 0; k < NUM_STREAMS; k++) begin
         if (pend_vec[k] && !any) begin
            any = 1'b1;
            grant_vec[k] = 1'b1;
            grant_idx = IDX_W'(k);
         end
      end
   end

   // R5
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));
endmodule

// File: rtl/dirstream_prefetch.sv
`timescale 1ns/1ps
module dirstream_prefetch #(
   parameter int ADDR_W = 32,
   parameter int NUM_STREAMS = 16,
   parameter int WINDOW = 16,
   parameter int DIST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr
);
   import dsp_pkg::*;

   localparam int IDX_W = $clog2(NUM_STREAMS);
   localparam logic signed [ADDR_W-1:0] DIST_S = ADDR_W'(DIST);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   initial begin : prm_chk
      if (NUM_STREAMS < 2 || (1 << IDX_W) != NUM_STREAMS)
         $error("NUM_STREAMS must be a power of two, at least 2");
      if (WINDOW < 1 || DIST < 1) $error("WINDOW and DIST must be positive");
      if (ADDR_W < 8) $error("ADDR_W too small");
   end

   strm_state_e                       st_q   [NUM_STREAMS];
   logic [NUM_STREAMS-1:0]            down_q;
   logic [NUM_STREAMS-1:0][ADDR_W-1:0] last_q;
   logic [NUM_STREAMS-1:0][ADDR_W-1:0] next_q;
   logic [NUM_STREAMS-1:0]            live_vec, pend_vec, grant_vec;

   logic             hit, fire;
   logic [IDX_W-1:0] hit_idx, oldest_idx, free_idx, alloc_idx, tgt_idx, grant_idx;
   logic             have_free;

   dsp_match #(.ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS), .WINDOW(WINDOW)) match_i (
      .clk(clk), .rst_n(rst_n), .probe_addr(miss_addr), .live_vec(live_vec),
      .last_vec(last_q), .hit(hit), .hit_idx(hit_idx));

   dsp_lru #(.NUM_STREAMS(NUM_STREAMS)) lru_i (
      .clk(clk), .rst_n(rst_n), .touch(miss_valid), .touch_idx(tgt_idx),
      .oldest_idx(oldest_idx));

   dsp_issue #(.NUM_STREAMS(NUM_STREAMS)) issue_i (
      .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .grant_vec(grant_vec),
      .any(pf_valid), .grant_idx(grant_idx));

   always_comb begin
      have_free = 1'b0;
      free_idx = '0;
      for (int k = NUM_STREAMS - 1; k >= 0; k--) begin
         if (!live_vec[k]) begin
            have_free = 1'b1;
            free_idx = IDX_W'(k);
         end
      end
   end

   assign alloc_idx = have_free ? free_idx : oldest_idx;
   assign tgt_idx   = hit ? hit_idx : alloc_idx;
   assign pf_addr   = next_q[grant_idx];
   assign fire      = pf_valid && pf_ready;

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_strm
      logic signed [ADDR_W-1:0] lead, lead_new;
      logic [ADDR_W-1:0]        delta, step_dst;
      logic                     mine, seed;

      assign live_vec[g] = (st_q[g] != ST_FREE);
      assign lead     = $signed(down_q[g] ? last_q[g] - next_q[g] : next_q[g] - last_q[g]);
      assign lead_new = $signed(down_q[g] ? miss_addr - next_q[g] : next_q[g] - miss_addr);
      assign pend_vec[g] = (st_q[g] == ST_LOCKED) && (lead >= 1) && (lead <= DIST_S);
      assign delta    = miss_addr - last_q[g];
      assign step_dst = delta[ADDR_W-1] ? miss_addr - ONE : miss_addr + ONE;
      assign mine     = miss_valid && hit && (hit_idx == IDX_W'(g));
      assign seed     = miss_valid && !hit && (alloc_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]   <= ST_FREE;
            down_q[g] <= 1'b0;
            last_q[g] <= '0;
            next_q[g] <= '0;
         end else begin
            if (fire && grant_vec[g])
               next_q[g] <= down_q[g] ? next_q[g] - ONE : next_q[g] + ONE;
            if (seed) begin
               st_q[g]   <= ST_SEEDED;
               down_q[g] <= 1'b0;
               last_q[g] <= miss_addr;
            end else if (mine && delta != '0) begin
               last_q[g] <= miss_addr;
               unique case (st_q[g])
                  ST_SEEDED: st_q[g] <= ST_LEAN;
                  ST_LEAN: begin
                     st_q[g]   <= ST_LOCKED;
                     down_q[g] <= delta[ADDR_W-1];
                     next_q[g] <= step_dst;
                  end
                  ST_LOCKED: begin
                     if (lead_new < 1)
                        next_q[g] <= down_q[g] ? miss_addr - ONE : miss_addr + ONE;
                  end
                  default: st_q[g] <= ST_FREE;
               endcase
            end
         end
      end
   end

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid && !pf_ready && !miss_valid |=> pf_valid && $stable(pf_addr));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !pf_valid);
endmodule

// File: tb/dirstream_prefetch_tb_top.sv
`timescale 1ns/1ps
module dirstream_prefetch_tb_top;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic          pf_valid;
   logic          pf_ready = 1'b1;
   logic [AW-1:0] pf_addr;

   int tests = 0;
   int fails = 0;
   logic [AW-1:0] expq[$];

   always #4 clk = ~clk;

   dirstream_prefetch dut_i (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

   task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compares each accepted request against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && pf_valid && pf_ready) begin
         if (expq.size() == 0) begin
            check(1'b0, "R5 unexpected request", pf_addr, '0);
         end else begin
            logic [AW-1:0] e;
            e = expq.pop_front();
            check(pf_addr == e, "R5 request order", pf_addr, e);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0; miss_valid = 1'b0; pf_ready = 1'b1;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic miss(input logic [AW-1:0] a);
      @(posedge clk); #1 miss_valid = 1'b1; miss_addr = a;
      @(posedge clk); #1 miss_valid = 1'b0;
   endtask

   task automatic expect_run(input logic [AW-1:0] first, input bit down, input int n);
      for (int k = 0; k < n; k++) expq.push_back(down ? first - AW'(k) : first + AW'(k));
   endtask

   task automatic drained(input string req);
      cyc(12);
      check(expq.size() == 0, req, AW'(expq.size()), '0);
      check(!pf_valid, req, AW'(pf_valid), '0);
   endtask

   initial begin
      do_reset();
      // R1
      check(!pf_valid, "R1 idle after reset", AW'(pf_valid), '0);

      // R2 / R3 / R5 ascending stream
      miss(1000); miss(1001); cyc(5);
      check(!pf_valid, "R2 training silent", AW'(pf_valid), '0);
      expect_run(1003, 1'b0, 4);
      miss(1002);
      drained("R5 ascending run of DIST");
      // R7 continue from stop point
      expect_run(1007, 1'b0, 1);
      miss(1003);
      drained("R7 continue ahead");
      // R4 17 blocks away opens a new stream; 16 away still matches the old one
      miss(1020); cyc(4);
      check(!pf_valid, "R4 beyond window opens new stream", AW'(pf_valid), '0);
      expect_run(1020, 1'b0, 4);
      miss(1019);
      drained("R4 inclusive edge / R7 restart past miss");

      // R3 disagreeing deltas, later one wins; R6 backpressure
      do_reset();
      miss(5000); miss(5003);
      pf_ready = 1'b0;
      miss(5001);
      for (int k = 0; k < 3; k++) begin
         cyc(1);
         check(pf_valid, "R6 valid held", AW'(pf_valid), 1);
         check(pf_addr == 5000, "R3 R6 addr held descending", pf_addr, 5000);
      end
      expect_run(5000, 1'b1, 4);
      pf_ready = 1'b1;
      drained("R3 descending run");

      // R9 zero-delta miss does not train
      do_reset();
      miss(2000); miss(2000); miss(2001); cyc(5);
      check(!pf_valid, "R9 repeat address not counted", AW'(pf_valid), '0);
      expect_run(2003, 1'b0, 4);
      miss(2002);
      drained("R9 trains after real deltas");

      // R8 replacement of least recently used entry
      do_reset();
      for (int k = 0; k < 16; k++) miss(AW'(100000 + k * 1000));
      miss(100000);
      miss(200000);
      miss(101001); miss(101002); cyc(5);
      check(!pf_valid, "R8 oldest stream evicted", AW'(pf_valid), '0);
      expect_run(100003, 1'b0, 4);
      miss(100001); miss(100002);
      drained("R8 refreshed stream survives");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule